// File: doc/BRIEF.md
# Scrambled AMI Burst Line Coder

This block is the digital symbol stage of a burst-mode, full-duplex link over one twisted pair. On the transmit side, a one-cycle strobe opens a burst. The block first sends a start mark that always stands for a logical one and never passes through the scrambler. It then takes a serial stream of 36 payload bits, one per clock. It scrambles each bit with a self-synchronizing scrambler on the polynomial x^9 + x^5 + 1 and line-codes it as alternate mark inversion: a one becomes a mark whose polarity is opposite to the previous mark, and a zero becomes no pulse. The mark polarity carries on across burst boundaries, so each start mark is opposite to the last mark of the burst before it.

On the receive side, the block watches a stream of ternary symbols and treats the first mark it sees while idle as a start mark. It descrambles the 36 symbols that follow with the matching descrambler and presents each recovered bit with a valid strobe. It marks the last bit of the burst with a done strobe. At all times it flags any two successive marks of the same polarity as a bipolar violation.

The caller supplies payload bits in its own frame order, for example two frames of 8 B1 bits, 8 B2 bits and 2 D bits. The receive side hands them back in the same order. Pulse shaping, equalization and clock recovery lie outside the block. It works on one symbol per clock in each direction.

Top module: `ami_burst_codec`

## Requirements
- R1: While rst_n is low and right after it is released, tx_sym is 00, and tx_busy, rx_bit, rx_bit_vld, rx_done and rx_viol are all 0.
- R2: A tx_start seen high on a rising edge while tx_busy is low is accepted. From the next cycle, tx_busy is high for exactly 36 cycles. tx_data is sampled on each of the 36 rising edges at which tx_busy is high, and the symbol for each sample appears in the cycle after that edge. When no burst is accepted, tx_sym is 00 in every cycle after a burst's last symbol.
- R3: The start mark is never scrambled. Each payload bit d is sent as line bit s = d XOR s(n-5) XOR s(n-9), where s(n-k) is the line bit sent k payload bits earlier. The nine-bit history resets to all ones and carries over from one burst to the next.
- R4: Symbol codes are 00 for no pulse, 01 for a positive mark and 10 for a negative mark. The code 11 is never sent. Every line one, start marks included, is a mark of the opposite polarity to the previous mark, across burst boundaries. The first mark after reset is positive.
- R5: A tx_start that is high while tx_busy is high is ignored. The burst in progress keeps its 36 payload symbols and its length, and the line returns to 00 afterwards.
- R6: While no receive burst is open, any mark (01 or 10) on rx_sym is taken as a start mark. The next 36 symbols are payload. For each one, rx_bit_vld is high in the following cycle and rx_bit = m XOR m(n-5) XOR m(n-9), where m is 1 for a mark and 0 otherwise. The history of m resets to all ones and carries over between bursts. The start-mark cycle itself yields no rx_bit_vld.
- R7: rx_done is high in exactly the cycle in which rx_bit_vld carries the 36th payload bit of a burst.
- R8: rx_viol is high in the cycle after a received mark whose polarity equals that of the previous received mark, whether a burst is open or not. The first mark after reset never raises it. Codes 00 and 11 are treated as no pulse and leave the polarity history unchanged.
- R9: When tx_sym is fed straight back into rx_sym, rx_bit reproduces the transmitted payload bits in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one symbol per cycle in each direction |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Opens a transmit burst when the transmitter is idle |
| tx_data | input | 1 | Serial payload bit, sampled while tx_busy is high |
| tx_busy | output | 1 | High while the transmitter is taking payload bits |
| tx_sym | output | 2 | Transmit symbol: 00 none, 01 positive mark, 10 negative mark |
| rx_sym | input | 2 | Received symbol, same coding; 11 is treated as no pulse |
| rx_bit | output | 1 | Descrambled payload bit |
| rx_bit_vld | output | 1 | rx_bit holds a payload bit this cycle |
| rx_done | output | 1 | The bit on rx_bit is the last of its burst |
| rx_viol | output | 1 | The previous received mark repeated the polarity before it |

## Verification
On every cycle the assertions check the following. Each transmit burst lasts exactly its payload length. Every burst opens with a mark. The line stays silent between bursts, never carries code 11, and never repeats a mark polarity. On receive, rx_done falls only on the last bit of each burst, a violation always follows a received mark, and a start mark is never itself reported as a bit. The following can only be shown by the bench's reference models, run over sweeps of payload patterns, back-to-back and interrupted bursts, and random ternary streams: the exact scrambled symbol values, the descrambled bit values, a stray start being ignored, and a payload making the round trip through loopback.

// File: rtl/ami_pkg.sv
package ami_pkg;

  typedef enum logic [1:0] {
    SYM_NONE = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b10,
    SYM_BAD  = 2'b11
  } ami_sym_e;

  // Line code for one bit: a one becomes a mark of the requested polarity.
  function automatic logic [1:0] ami_encode(input logic one, input logic neg);
    ami_sym_e s;
    if (!one)     s = SYM_NONE;
    else if (neg) s = SYM_NEG;
    else          s = SYM_POS;
    return s;
  endfunction

  function automatic logic sym_is_mark(input logic [1:0] s);
    return (s == SYM_POS) || (s == SYM_NEG);
  endfunction

  function automatic logic sym_is_neg(input logic [1:0] s);
    return s == SYM_NEG;
  endfunction

endpackage

// File: rtl/ami_sst.sv
// Self-synchronizing scrambler / descrambler stage.
// hist[0] is the most recent line bit; the taps sit at delays TAP and LEN.
module ami_sst #(
  parameter int LEN        = 9,
  parameter int TAP        = 5,
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic din,
  output logic dout
);

  logic [LEN-1:0] hist;
  logic           line_bit;

  assign dout = din ^ hist[TAP-1] ^ hist[LEN-1];

  generate
    if (DESCRAMBLE) begin : g_desc
      assign line_bit = din;   // receiver history follows the line
    end else begin : g_scr
      assign line_bit = dout;  // transmitter history follows what it sends
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '1;
    else if (shift_en) hist <= {hist[LEN-2:0], line_bit};
  end

endmodule

// File: rtl/ami_tx_framer.sv
module ami_tx_framer
  import ami_pkg::*;
#(
  parameter int PAYLOAD_BITS = 36,
  parameter int SCR_LEN      = 9,
  parameter int SCR_TAP      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_start,
  input  logic       tx_data,
  output logic       tx_busy,
  output logic [1:0] tx_sym,
  output logic       tx_accept
);

  localparam int CNT_W = $clog2(PAYLOAD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAYLOAD_BITS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             next_neg_q;
  logic [1:0]       sym_q;
  logic             scr_bit;
  logic             emit_one;

  ami_sst #(.LEN(SCR_LEN), .TAP(SCR_TAP), .DESCRAMBLE(1'b0)) u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(busy_q),
    .din     (tx_data),
    .dout    (scr_bit)
  );

  assign tx_accept = tx_start & ~busy_q;
  assign emit_one  = tx_accept | (busy_q & scr_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      next_neg_q <= 1'b0;
      sym_q      <= SYM_NONE;
    end else begin
      if (tx_accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        sym_q  <= ami_encode(1'b1, next_neg_q);
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
        sym_q <= ami_encode(scr_bit, next_neg_q);
      end else begin
        sym_q <= SYM_NONE;
      end
      if (emit_one) next_neg_q <= ~next_neg_q;
    end
  end

  assign tx_busy = busy_q;
  assign tx_sym  = sym_q;

endmodule

// File: rtl/ami_rx_deframer.sv
module ami_rx_deframer
  import ami_pkg::*;
#(
  parameter int PAYLOAD_BITS = 36,
  parameter int SCR_LEN      = 9,
  parameter int SCR_TAP      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_sym,
  output logic       rx_bit,
  output logic       rx_bit_vld,
  output logic       rx_done,
  output logic       rx_viol,
  output logic       rx_start_seen
);

  localparam int CNT_W = $clog2(PAYLOAD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAYLOAD_BITS - 1);

  logic             in_pay_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             last_neg_q;
  logic             mark;
  logic             neg;
  logic             plain;
  logic             pol_clash;
  logic             bit_q, vld_q, done_q, viol_q;

  assign mark          = sym_is_mark(rx_sym);
  assign neg           = sym_is_neg(rx_sym);
  assign rx_start_seen = ~in_pay_q & mark;
  assign pol_clash     = mark & seen_q & (neg == last_neg_q);

  ami_sst #(.LEN(SCR_LEN), .TAP(SCR_TAP), .DESCRAMBLE(1'b1)) u_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(in_pay_q),
    .din     (mark),
    .dout    (plain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pay_q   <= 1'b0;
      cnt_q      <= '0;
      seen_q     <= 1'b0;
      last_neg_q <= 1'b0;
      bit_q      <= 1'b0;
      vld_q      <= 1'b0;
      done_q     <= 1'b0;
      viol_q     <= 1'b0;
    end else begin
      if (rx_start_seen) begin
        in_pay_q <= 1'b1;
        cnt_q    <= '0;
      end else if (in_pay_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) in_pay_q <= 1'b0;
      end
      vld_q  <= in_pay_q;
      bit_q  <= in_pay_q & plain;
      done_q <= in_pay_q && (cnt_q == LAST);
      viol_q <= pol_clash;
      if (mark) begin
        seen_q     <= 1'b1;
        last_neg_q <= neg;
      end
    end
  end

  assign rx_bit     = bit_q;
  assign rx_bit_vld = vld_q;
  assign rx_done    = done_q;
  assign rx_viol    = viol_q;

endmodule

// File: rtl/ami_burst_codec.sv
module ami_burst_codec #(
  parameter int PAYLOAD_BITS = 36,
  parameter int SCR_LEN      = 9,
  parameter int SCR_TAP      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_start,
  input  logic       tx_data,
  output logic       tx_busy,
  output logic [1:0] tx_sym,
  input  logic [1:0] rx_sym,
  output logic       rx_bit,
  output logic       rx_bit_vld,
  output logic       rx_done,
  output logic       rx_viol
);

  logic tx_accept;
  logic rx_start_seen;

  ami_tx_framer #(
    .PAYLOAD_BITS(PAYLOAD_BITS), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_start (tx_start),
    .tx_data  (tx_data),
    .tx_busy  (tx_busy),
    .tx_sym   (tx_sym),
    .tx_accept(tx_accept)
  );

  ami_rx_deframer #(
    .PAYLOAD_BITS(PAYLOAD_BITS), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)
  ) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_sym       (rx_sym),
    .rx_bit       (rx_bit),
    .rx_bit_vld   (rx_bit_vld),
    .rx_done      (rx_done),
    .rx_viol      (rx_viol),
    .rx_start_seen(rx_start_seen)
  );

endmodule

// File: rtl/ami_burst_codec_chk.sv
module ami_burst_codec_chk
  import ami_pkg::*;
#(
  parameter int PAYLOAD_BITS = 36
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] tx_sym,
  input logic       tx_busy,
  input logic       tx_accept,
  input logic [1:0] rx_sym,
  input logic       rx_bit_vld,
  input logic       rx_done,
  input logic       rx_viol,
  input logic       rx_start_seen
);

  localparam int W = $clog2(PAYLOAD_BITS + 2);
  localparam logic [W-1:0] RUN_LEN  = W'(PAYLOAD_BITS);
  localparam logic [W-1:0] BIT_LAST = W'(PAYLOAD_BITS - 1);

  logic [W-1:0] busy_run;
  logic [W-1:0] bit_cnt;
  logic         tx_seen, tx_last_neg;
  logic         tx_mark, tx_neg, rx_mark;

  assign tx_mark = sym_is_mark(tx_sym);
  assign tx_neg  = sym_is_neg(tx_sym);
  assign rx_mark = sym_is_mark(rx_sym);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run    <= '0;
      bit_cnt     <= '0;
      tx_seen     <= 1'b0;
      tx_last_neg <= 1'b0;
    end else begin
      busy_run <= tx_busy ? busy_run + 1'b1 : '0;
      if (rx_bit_vld) bit_cnt <= (bit_cnt == BIT_LAST) ? '0 : bit_cnt + 1'b1;
      if (tx_mark) begin
        tx_seen     <= 1'b1;
        tx_last_neg <= tx_neg;
      end
    end
  end

  // R2 (and R5: a re-accepted start would stretch the run)
  a_r2_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> busy_run == RUN_LEN);

  a_r2_start_mark: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> tx_mark);

  a_r2_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> tx_busy && tx_mark);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy && !$past(tx_busy) |-> tx_sym == 2'b00);

  a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sym != 2'b11);

  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mark && tx_seen |-> tx_neg != tx_last_neg);

  a_r6_start_no_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_seen |=> !rx_bit_vld);

  a_r7_done_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rx_bit_vld);

  a_r7_done_position: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_vld |-> rx_done == (bit_cnt == BIT_LAST));

  a_r8_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rx_viol |-> $past(rx_mark));

endmodule

bind ami_burst_codec ami_burst_codec_chk #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_sym       (tx_sym),
  .tx_busy      (tx_busy),
  .tx_accept    (tx_accept),
  .rx_sym       (rx_sym),
  .rx_bit_vld   (rx_bit_vld),
  .rx_done      (rx_done),
  .rx_viol      (rx_viol),
  .rx_start_seen(rx_start_seen)
);

// File: tb/ami_burst_codec_test.sv
`timescale 1ns/1ps
module ami_burst_codec_test;

  localparam int NB = 36;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       tx_start = 1'b0;
  logic       tx_data = 1'b0;
  logic       loop_en = 1'b0;
  logic [1:0] rx_drv = 2'b00;
  logic [1:0] tx_sym;
  logic       tx_busy, rx_bit, rx_bit_vld, rx_done, rx_viol;
  logic [1:0] rx_in;
  logic [1:0] cap;

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;
  bit pq[$];

  always #2 clk = ~clk;

  assign rx_in = loop_en ? tx_sym : rx_drv;

  ami_burst_codec uut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_data(tx_data),
    .tx_busy(tx_busy), .tx_sym(tx_sym), .rx_sym(rx_in), .rx_bit(rx_bit),
    .rx_bit_vld(rx_bit_vld), .rx_done(rx_done), .rx_viol(rx_viol)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- transmit reference ----------------
  int t_pol;       // +1: next mark positive, -1: negative
  bit t_hist[9];   // t_hist[k] = line bit sent k+1 payload bits ago

  function automatic void tmodel_reset();
    t_pol = 1;
    for (int i = 0; i < 9; i++) t_hist[i] = 1'b1;
  endfunction

  function automatic int mark_code();
    int c;
    c = (t_pol > 0) ? 1 : 2;
    t_pol = -t_pol;
    return c;
  endfunction

  function automatic int tx_expect_bit(input bit d);
    bit s;
    s = d ^ t_hist[4] ^ t_hist[8];
    for (int i = 8; i > 0; i--) t_hist[i] = t_hist[i-1];
    t_hist[0] = s;
    return s ? mark_code() : 0;
  endfunction

  // ---------------- receive reference (monitor) ----------------
  bit r_hunt, r_seen, r_last_neg;
  int r_cnt;
  bit r_hist[9];

  always @(posedge clk) cap <= rx_in;

  always @(negedge clk) begin
    if (!rst_n) begin
      r_hunt = 1; r_seen = 0; r_last_neg = 0; r_cnt = 0;
      for (int i = 0; i < 9; i++) r_hist[i] = 1'b1;
      pq.delete();
      chk("R1 rx_bit_vld in reset", rx_bit_vld, 0);
      chk("R1 rx_bit in reset", rx_bit, 0);
      chk("R1 rx_done in reset", rx_done, 0);
      chk("R1 rx_viol in reset", rx_viol, 0);
    end else begin
      bit mk, ng, ev, ed, eb, ex;
      mk = (cap == 2'b01) || (cap == 2'b10);
      ng = (cap == 2'b10);
      ex = mk && r_seen && (ng == r_last_neg);
      if (mk) begin r_seen = 1; r_last_neg = ng; end
      ev = 0; ed = 0; eb = 0;
      if (r_hunt) begin
        if (mk) begin r_hunt = 0; r_cnt = 0; end
      end else begin
        eb = mk ^ r_hist[4] ^ r_hist[8];
        for (int i = 8; i > 0; i--) r_hist[i] = r_hist[i-1];
        r_hist[0] = mk;
        ev = 1;
        ed = (r_cnt == NB - 1);
        r_cnt++;
        if (r_cnt == NB) r_hunt = 1;
      end
      chk("R6 rx_bit_vld", rx_bit_vld, ev);
      chk("R7 rx_done", rx_done, ed);
      chk("R8 rx_viol", rx_viol, ex);
      if (ev) begin
        chk("R6 rx_bit descrambled", rx_bit, eb);
        if (pq.size() > 0) chk("R9 loopback payload", rx_bit, pq.pop_front());
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_burst(input bit [NB-1:0] p, input bit poke_mid, input bit chain);
    tx_start = 1'b1;
    @(negedge clk);
    chk("R2 busy after accept", tx_busy, 1);
    chk("R3 start mark unscrambled", tx_sym, mark_code());
    #1;
    for (int k = 0; k < NB; k++) begin
      tx_data  = p[k];
      tx_start = poke_mid && (k == 7 || k == 20);
      if (loop_en) pq.push_back(p[k]);
      @(negedge clk);
      chk("R4 payload symbol", tx_sym, tx_expect_bit(p[k]));
      if (poke_mid) chk("R5 busy under stray start", tx_busy, (k != NB - 1));
      else          chk("R2 busy window", tx_busy, (k != NB - 1));
      #1;
    end
    tx_start = 1'b0;
    if (!chain) begin
      @(negedge clk);
      chk("R5 line quiet after burst", tx_sym, 0);
      chk("R2 idle after burst", tx_busy, 0);
      #1;
    end
  endtask

  task automatic feed(input logic [1:0] s);
    rx_drv = s;
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tx_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 tx_sym in reset", tx_sym, 0);
    chk("R1 tx_busy in reset", tx_busy, 0);
    #1;
    rst_n = 1'b1;
    tmodel_reset();
    @(negedge clk);
    chk("R1 tx_sym after release", tx_sym, 0);
    chk("R1 tx_busy after release", tx_busy, 0);
    #1;
  endtask

  initial begin
    bit [NB-1:0] p;
    int unsigned lcg;
    lcg = 32'h1234_5678;
    tmodel_reset();
    #1;
    loop_en = 1'b1;
    do_reset();

    repeat (3) begin
      @(negedge clk);
      chk("R2 idle line", tx_sym, 0);
      #1;
    end

    send_burst('0, 0, 0);
    send_burst('1, 0, 0);
    send_burst({9{4'b0101}}, 0, 1);
    send_burst({9{4'b1010}}, 1, 0);
    for (int w = 0; w < NB; w++) begin
      p = '0;
      p[w] = 1'b1;
      send_burst(p, w[0], w[1]);
    end
    for (int r = 0; r < 30; r++) begin
      lcg = lcg * 1103515245 + 12345;
      p[31:0] = lcg;
      lcg = lcg * 1103515245 + 12345;
      p[NB-1:32] = lcg[NB-33:0];
      send_burst(p, r[1], r[0]);
    end
    repeat (6) @(negedge clk);
    #1;
    chk("R9 all payload returned", pq.size(), 0);

    // direct receive stimulus
    loop_en = 1'b0;
    rx_drv = 2'b00;
    do_reset();
    feed(2'b00); feed(2'b00);
    feed(2'b01);                       // R8 first mark, no violation; opens burst
    feed(2'b01);                       // R8 repeat polarity
    feed(2'b00); feed(2'b01);          // R8 repeat across a gap
    feed(2'b10); feed(2'b11);          // R8 code 11 is no pulse
    feed(2'b10);                       // R8 repeat after 11
    for (int i = 0; i < 40; i++) feed(2'b00);
    for (int i = 0; i < 500; i++) begin
      lcg = lcg * 1103515245 + 12345;
      feed(lcg[17:16]);
    end
    for (int i = 0; i < 60; i++) feed(2'b00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule